// File: doc/BRIEF.md
# Partial-Write Merge Stall Tracker

This block is a small architectural register file that follows how each register was last written. It takes writes of four widths: the low byte, the second byte, the low half-word and the full word. A write can also be flagged as a self-zeroing idiom, meaning XOR of a register with itself or, when the option is on, SUB of a register from itself. Each register keeps a hidden marker that is either clean or dirty. Only the zeroing idiom makes a register clean. Any other write, and any pulse on the interrupt input, makes it dirty.

A narrow write to a clean register zero-extends into the full word for free. A narrow write to a dirty register must be combined with the untouched bits of the older value, so it leaves a merge pending. A full-width read of a register with a pending merge raises `stall` for a fixed merge penalty and then returns the combined word. A pending merge also disappears by itself once the write retires, after a fixed delay. The surrounding logic holds its requests steady while `stall` is high.

Top module: `prs_tracker`

## Requirements
- R1: After reset every register reads as zero and is dirty, and `stall` and `rd_valid` are low.
- R2: A write with `wr_kind`=0 and `wr_size`=3 stores all 32 bits of `wr_data`, marks the register dirty and clears any pending merge.
- R3: A write with `wr_kind`=1 (XOR idiom), or `wr_kind`=2 (SUB idiom, with `SUB_IDIOM_EN`=1, the default), stores zero whatever `wr_data` holds, marks the register clean and clears any pending merge.
- R4: A narrow write to a clean register zero-extends. Bits outside the field become 0 and no merge becomes pending. A read with no pending merge gives `rd_valid` and `rd_data` one cycle after the edge that samples `rd_en`, with no stall.
- R5: The field positions are fixed. Size 0 writes bits 7:0 from `wr_data[7:0]`. Size 1 writes bits 15:8 from `wr_data[15:8]`. Size 2 writes bits 15:0. On a dirty register, all other bits keep their old values.
- R6: A narrow write to a dirty register makes a merge pending. A read sampled while it is pending raises `stall` for exactly `MERGE_PEN` cycles. In the cycle `stall` falls, `rd_valid` is high with the merged word.
- R7: A low-byte write and then a second-byte write after a zeroing idiom count as two writes. The second one sees a dirty register, so a following read stalls.
- R8: A pulse on `irq` marks every register dirty. A narrow write after it leaves a merge pending, even if the register was zeroed by an idiom.
- R9: A pending merge retires by itself. A read sampled k edges after the narrow write stalls when 1 <= k <= `RETIRE_DLY` and does not stall when k > `RETIRE_DLY`.
- R10: While `stall` is high, writes and reads are not accepted. A write held during a stalled read takes effect only after `stall` falls, so the stalled read returns the older value.
- R11: A completed merge clears the pending state, so an immediate second read of the same register does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 3 | Write register index |
| wr_size | input | 2 | 0 low byte, 1 second byte, 2 low half, 3 full word |
| wr_kind | input | 2 | 0 plain, 1 XOR self-zero, 2 SUB self-zero, 3 plain |
| wr_data | input | 32 | Write data, aligned to the field |
| rd_en | input | 1 | Full-width read request |
| rd_addr | input | 3 | Read register index |
| irq | input | 1 | Interrupt taken; all markers become dirty |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is valid |
| stall | output | 1 | Merge in progress; requests held off |

## Verification
The hardest case to reach is the exact edge of retirement. A read has to be sampled either `RETIRE_DLY` edges or one edge more after a dirty narrow write, and any earlier read of that register would merge it and hide the boundary. The bench counts edges from the write, inserts an exact number of idle cycles and then issues a single read. For the case of a write held during a stall, the bench raises the write only after `stall` is seen high. It then lowers the read in the cycle `stall` falls, so the two requests are accepted on different edges.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [1:0] {
    SZ_B0 = 2'd0,
    SZ_B1 = 2'd1,
    SZ_H  = 2'd2,
    SZ_W  = 2'd3
  } wsize_e;

  typedef enum logic [1:0] {
    WK_PLAIN = 2'd0,
    WK_XOR   = 2'd1,
    WK_SUB   = 2'd2,
    WK_ALT   = 2'd3
  } wkind_e;
endpackage

// File: rtl/prs_merge_unit.sv
module prs_merge_unit #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] new_data,
  input  logic [1:0]        size,
  input  logic              clean,
  output logic [DATA_W-1:0] result
);
  import prs_pkg::*;

  localparam int BYTE_W = 8;
  localparam int HALF_W = 2 * BYTE_W;

  logic [DATA_W-1:0] base;

  always_comb begin
    // a clean register holds no older data worth keeping
    base = clean ? '0 : old_val;
    result = base;
    unique case (size)
      SZ_B0:   result[BYTE_W-1:0]      = new_data[BYTE_W-1:0];
      SZ_B1:   result[HALF_W-1:BYTE_W] = new_data[HALF_W-1:BYTE_W];
      SZ_H:    result[HALF_W-1:0]      = new_data[HALF_W-1:0];
      default: result                  = new_data;
    endcase
  end
endmodule

// File: rtl/prs_reg_state.sv
module prs_reg_state #(
  parameter int RETIRE_DLY = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic irq,
  input  logic wr_hit,
  input  logic wr_partial,
  input  logic wr_zeroing,
  input  logic merge_clr,
  output logic clean_q,
  output logic pend_q
);
  localparam int CNT_W = $clog2(RETIRE_DLY + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clean_q <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (wr_hit) begin
        if (wr_zeroing) begin
          clean_q <= 1'b1;
          pend_q  <= 1'b0;
        end else if (wr_partial && !clean_q) begin
          clean_q <= 1'b0;
          pend_q  <= 1'b1;
          cnt_q   <= CNT_W'(RETIRE_DLY);
        end else begin
          clean_q <= 1'b0;
          pend_q  <= 1'b0;
        end
      end else if (merge_clr) begin
        pend_q <= 1'b0;
      end else if (pend_q) begin
        if (cnt_q <= CNT_W'(1)) pend_q <= 1'b0;
        else                    cnt_q  <= cnt_q - CNT_W'(1);
      end
      if (irq) clean_q <= 1'b0;
    end
  end

  assert_zero_marks_clean_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wr_zeroing && !irq) |=> (clean_q && !pend_q));

  assert_irq_dirties_R8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !clean_q);

  assert_dirty_partial_pends_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wr_partial && !wr_zeroing && !clean_q) |=> pend_q);

  assert_full_write_no_pend_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !wr_partial && !wr_zeroing) |=> (!pend_q && !clean_q));
endmodule

// File: rtl/prs_read_ctrl.sv
module prs_read_ctrl #(
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 32,
  parameter int MERGE_PEN = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rd_en,
  input  logic [$clog2(NUM_REGS)-1:0] rd_addr,
  input  logic                        sel_pending,
  input  logic [DATA_W-1:0]           sel_word,
  output logic [$clog2(NUM_REGS)-1:0] sel_addr,
  output logic                        merge_clr,
  output logic                        stall,
  output logic                        rd_valid,
  output logic [DATA_W-1:0]           rd_data
);
  localparam int AW    = $clog2(NUM_REGS);
  localparam int PEN_W = $clog2(MERGE_PEN + 1);

  logic             busy_q;
  logic [PEN_W-1:0] pcnt_q;
  logic [AW-1:0]    lat_q;

  assign sel_addr  = busy_q ? lat_q : rd_addr;
  assign merge_clr = busy_q && (pcnt_q == '0);
  assign stall     = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      pcnt_q   <= '0;
      lat_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (busy_q) begin
        if (pcnt_q == '0) begin
          busy_q   <= 1'b0;
          rd_valid <= 1'b1;
          rd_data  <= sel_word;
        end else begin
          pcnt_q <= pcnt_q - PEN_W'(1);
        end
      end else if (rd_en) begin
        if (sel_pending) begin
          busy_q <= 1'b1;
          lat_q  <= rd_addr;
          pcnt_q <= PEN_W'(MERGE_PEN - 1);
        end else begin
          rd_valid <= 1'b1;
          rd_data  <= sel_word;
        end
      end
    end
  end

  assert_stall_needs_pending_read_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> $past(rd_en && sel_pending));

  assert_merge_returns_data_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> rd_valid);

  assert_clean_read_no_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (!stall && rd_en && !sel_pending) |=> (rd_valid && !stall));
endmodule

// File: rtl/prs_tracker.sv
module prs_tracker #(
  parameter int NUM_REGS     = 8,
  parameter int DATA_W       = 32,
  parameter int RETIRE_DLY   = 12,
  parameter int MERGE_PEN    = 6,
  parameter bit SUB_IDIOM_EN = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_addr,
  input  logic [1:0]                  wr_size,
  input  logic [1:0]                  wr_kind,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        rd_en,
  input  logic [$clog2(NUM_REGS)-1:0] rd_addr,
  input  logic                        irq,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rd_valid,
  output logic                        stall
);
  import prs_pkg::*;

  localparam int AW = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] clean_v, pend_v;
  logic [AW-1:0]       sel_addr;
  logic                merge_clr;
  logic                wr_go, is_zeroing, is_sub_plain, wr_partial;
  logic [1:0]          eff_size;
  logic [DATA_W-1:0]   eff_data, merged;

  assign wr_go        = wr_en && !stall;
  assign is_zeroing   = (wr_kind == WK_XOR) || ((wr_kind == WK_SUB) && SUB_IDIOM_EN);
  assign is_sub_plain = (wr_kind == WK_SUB) && !SUB_IDIOM_EN;
  assign eff_size     = (is_zeroing || is_sub_plain) ? SZ_W : wr_size;
  assign eff_data     = (is_zeroing || is_sub_plain) ? '0 : wr_data;
  assign wr_partial   = (eff_size != SZ_W);

  prs_merge_unit #(.DATA_W(DATA_W)) u_merge (
    .old_val  (regs_q[wr_addr]),
    .new_data (eff_data),
    .size     (eff_size),
    .clean    (clean_v[wr_addr]),
    .result   (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (wr_go) begin
      regs_q[wr_addr] <= merged;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_state
    prs_reg_state #(.RETIRE_DLY(RETIRE_DLY)) u_state (
      .clk        (clk),
      .rst        (rst),
      .irq        (irq),
      .wr_hit     (wr_go && (wr_addr == AW'(g))),
      .wr_partial (wr_partial),
      .wr_zeroing (is_zeroing),
      .merge_clr  (merge_clr && (sel_addr == AW'(g))),
      .clean_q    (clean_v[g]),
      .pend_q     (pend_v[g])
    );
  end

  prs_read_ctrl #(
    .NUM_REGS  (NUM_REGS),
    .DATA_W    (DATA_W),
    .MERGE_PEN (MERGE_PEN)
  ) u_rctl (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .sel_pending (pend_v[sel_addr]),
    .sel_word    (regs_q[sel_addr]),
    .sel_addr    (sel_addr),
    .merge_clr   (merge_clr),
    .stall       (stall),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
  );

  assert_stall_holds_addr_R10: assert property (@(posedge clk) disable iff (rst)
    (stall && $past(stall)) |-> $stable(sel_addr));

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!stall && !rd_valid));
endmodule

// File: tb/prs_tracker_tb.sv
module prs_tracker_tb;
  localparam int RET = 12;
  localparam int PEN = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0, irq = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [1:0] wr_size = 0, wr_kind = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic rd_valid, stall;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_val [8];
  bit m_clean [8];
  bit m_pend [8];
  int m_wedge [8];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prs_tracker #(.RETIRE_DLY(RET), .MERGE_PEN(PEN)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_kind(wr_kind), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .irq(irq), .rd_data(rd_data), .rd_valid(rd_valid), .stall(stall)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_write(input int r, input int sz, input int kind, input logic [31:0] d);
    logic [31:0] base;
    if (kind == 1 || kind == 2) begin
      m_val[r] = 0; m_clean[r] = 1; m_pend[r] = 0;
    end else if (sz == 3) begin
      m_val[r] = d; m_clean[r] = 0; m_pend[r] = 0;
    end else begin
      base = m_clean[r] ? 32'h0 : m_val[r];
      case (sz)
        0: base[7:0]  = d[7:0];
        1: base[15:8] = d[15:8];
        default: base[15:0] = d[15:0];
      endcase
      m_val[r] = base;
      if (!m_clean[r]) begin m_pend[r] = 1; m_wedge[r] = cyc; end
      m_clean[r] = 0;
    end
  endtask

  task automatic do_write(input int r, input int sz, input int kind, input logic [31:0] d);
    wr_en = 1; wr_addr = 3'(r); wr_size = 2'(sz); wr_kind = 2'(kind); wr_data = d;
    @(negedge clk);
    model_write(r, sz, kind, d);
    wr_en = 0;
  endtask

  task automatic do_read(input int r, input string req);
    int n = 0;
    bit exp_st;
    rd_en = 1; rd_addr = 3'(r);
    @(negedge clk);
    exp_st = m_pend[r] && ((cyc - m_wedge[r]) <= RET);
    while (stall && n < 100) begin n++; @(negedge clk); end
    rd_en = 0;
    chk(n == (exp_st ? PEN : 0), {req, " stall cycles"}, 32'(n), exp_st ? PEN : 0);
    chk(rd_valid === 1'b1 && rd_data === m_val[r], {req, " read data"}, rd_data, m_val[r]);
    m_pend[r] = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_irq();
    irq = 1;
    @(negedge clk);
    irq = 0;
    for (int i = 0; i < 8; i++) m_clean[i] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_clean[i] = 0; m_pend[i] = 0; m_wedge[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: idle outputs and zero contents after reset
    chk(!stall && !rd_valid, "R1 idle outputs", {30'b0, stall, rd_valid}, 0);
    for (int r = 0; r < 8; r++) do_read(r, "R1 reset value");
    // R1: registers start dirty, so a narrow write leaves a merge pending
    do_write(7, 0, 0, 32'h0000_00C3);
    do_read(7, "R1 dirty after reset");

    // R2/R4/R5/R6/R11: sweep every register, size and starting marker
    for (int r = 0; r < 8; r++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int st = 0; st < 2; st++) begin
          logic [31:0] d;
          d = 32'h1234_5678 + 32'(r) * 32'h0101_0101 + 32'(sz) * 32'h0000_1111;
          if (st == 0) do_write(r, 3, 1, 32'hFFFF_FFFF);
          else         do_write(r, 3, 0, ~d);
          do_write(r, sz, 0, d);
          do_read(r, st == 0 ? "R4 clean narrow write" : (sz == 3 ? "R2 full write" : "R5 R6 dirty merge"));
          do_read(r, "R11 second read");
        end
      end
    end

    // R3: SUB idiom ignores data and leaves register clean
    do_write(1, 3, 0, 32'hDEAD_BEEF);
    do_write(1, 0, 2, 32'hFFFF_FFFF);
    do_write(1, 2, 0, 32'h0000_ABCD);
    do_read(1, "R3 sub idiom clean");

    // R7: low byte then second byte after zeroing
    do_write(5, 3, 1, 32'h0);
    do_write(5, 0, 0, 32'h0000_0011);
    do_write(5, 1, 0, 32'h0000_2200);
    do_read(5, "R7 two byte writes");

    // R8: interrupt discards clean marker
    do_write(6, 3, 1, 32'h0);
    pulse_irq();
    do_write(6, 0, 0, 32'h0000_0077);
    do_read(6, "R8 irq dirties");

    // R9: retirement boundary, k = RET stalls, k = RET+1 does not
    do_write(3, 3, 0, 32'hCAFE_0000);
    do_write(3, 0, 0, 32'h0000_0042);
    idle(RET - 1);
    chk(m_pend[3] && (cyc + 1 - m_wedge[3]) == RET, "R9 boundary setup", 32'(cyc + 1 - m_wedge[3]), RET);
    do_read(3, "R9 last pending edge");
    do_write(3, 1, 0, 32'h0000_5500);
    idle(RET);
    do_read(3, "R9 retired");

    // R10: write held during a stalled read lands after stall falls
    do_write(2, 3, 0, 32'h0BAD_0000);
    do_write(2, 0, 0, 32'h0000_0099);
    rd_en = 1; rd_addr = 3'd2;
    @(negedge clk);
    chk(stall === 1'b1, "R10 stall raised", {31'b0, stall}, 1);
    wr_en = 1; wr_addr = 3'd2; wr_size = 2'd3; wr_kind = 2'd0; wr_data = 32'h7777_8888;
    for (int i = 0; i < 100 && stall; i++) @(negedge clk);
    chk(rd_valid === 1'b1 && rd_data === m_val[2], "R10 stalled read old value", rd_data, m_val[2]);
    rd_en = 0;
    m_pend[2] = 0;
    @(negedge clk);
    wr_en = 0;
    model_write(2, 3, 0, 32'h7777_8888);
    do_read(2, "R10 held write applied");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule